// File: doc/BRIEF.md
# Windowed Instruction RAM with Range-Decoded Hits

This block replaces an instruction cache with a fixed on-chip RAM that stores no tags. A fetch counts as a hit only when its address falls inside one aligned, power-of-two address window and a fetch-enable input is set. A hit returns the instruction word on the clock after the request, as a cache hit would. A fetch outside the window, or any fetch while the enable is low, is forwarded to the external bus path. The window can be sized up to 512 KB through its parameter.

A second port on the data bus reaches the same RAM whatever the state of the enable. Boot code running from ROM can therefore copy the program image into the window with data-bus stores, then set the enable and branch into the RAM. The RAM has a single port. When both buses claim it in the same cycle, the data bus is served and the fetch is stalled for that cycle. All status outputs are registered. The read data comes straight from the RAM's output register, so the block maps onto an FPGA block RAM with per-byte write enables.

Top module: `imem_window`

## Requirements
- R1: In the cycle after synchronous reset is released, `if_valid`, `if_stall`, `ext_req` and `dp_rvalid` are all low.
- R2: A fetch to an address in the window, with `fetch_en` high and no data-bus access to the window in the same cycle, raises `if_valid` on the next clock with the stored word on `if_data`, and leaves `ext_req` low.
- R3: A fetch to an address outside the window raises `ext_req` on the next clock with `ext_addr` equal to the fetch address, and leaves `if_valid` low.
- R4: While `fetch_en` is low, a fetch to an address in the window is treated as a miss: `ext_req` rises on the next clock with the fetch address, and `if_valid` stays low.
- R5: A data-bus write to the window updates only the byte lanes whose `dp_be` bit is set. Bit i covers data bits 8i+7 down to 8i, and the word index is given by address bits above the two byte-offset bits.
- R6: A data-bus read from the window raises `dp_rvalid` on the next clock, with the stored word on `dp_rdata`.
- R7: A data-bus access outside the window is ignored. A read raises no `dp_rvalid`, and a write leaves every RAM word unchanged, including the word whose in-window index matches the low address bits.
- R8: When a fetch that would hit and a data-bus access to the window arrive in the same cycle, the data access is performed. On the next clock `if_stall` is high, and both `if_valid` and `ext_req` are low. A data access outside the window never stalls a fetch.
- R9: The data-bus port reads and writes the window whether `fetch_en` is high or low.
- R10: The window is the aligned range from the base up to the base plus the size. The last word of this range hits. The word just above it and the word just below the base both miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_en | input | 1 | Enables hits for instruction fetches |
| if_req | input | 1 | Instruction fetch request |
| if_addr | input | ADDR_W | Fetch byte address |
| if_valid | output | 1 | Fetch hit, data on if_data this cycle |
| if_stall | output | 1 | Fetch lost the RAM to the data bus, retry |
| if_data | output | DATA_W | Fetched instruction word |
| ext_req | output | 1 | Fetch missed, forwarded to external bus |
| ext_addr | output | ADDR_W | Address of the forwarded fetch |
| dp_req | input | 1 | Data-bus access request |
| dp_we | input | 1 | Data-bus write (1) or read (0) |
| dp_be | input | DATA_W/8 | Byte enables for data-bus writes |
| dp_addr | input | ADDR_W | Data-bus byte address |
| dp_wdata | input | DATA_W | Data-bus write data |
| dp_rvalid | output | 1 | Data-bus read data valid |
| dp_rdata | output | DATA_W | Data-bus read data |

## Verification
Every status flag is a register loaded from the request one cycle earlier. A wrong range decode, a wrong enable gate or a wrong arbitration choice therefore shows on `if_valid`, `if_stall` or `ext_req` exactly one clock after the offending request. A byte-lane or index error in the RAM stays hidden until that word is read again. For this reason each written word is read back through the data port or fetched, including words next to a partial write and the word aliased by an out-of-window store. A stall that drops the data access would show as a missing `dp_rvalid` or a stale word on a later fetch.

// File: rtl/imem_window_pkg.sv
package imem_window_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic {
    SRC_FETCH = 1'b0,
    SRC_DATA  = 1'b1
  } ram_src_e;
endpackage

// File: rtl/imem_range_match.sv
module imem_range_match #(
  parameter int ADDR_W = 32,
  parameter int LSB    = 12,
  parameter logic [ADDR_W-1:0] BASE = '0
) (
  input  logic [ADDR_W-1:LSB] tag,
  output logic                hit
);
  // Only the bits above the window size take part in the compare.
  assign hit = (tag == BASE[ADDR_W-1:LSB]);
endmodule

// File: rtl/imem_port_arb.sv
module imem_port_arb
  import imem_window_pkg::*;
#(
  parameter int IDX_W  = 10,
  parameter int DATA_W = 32,
  parameter int LANES  = DATA_W / BYTE_W
) (
  input  logic              f_claim,
  input  logic              d_claim,
  input  logic [IDX_W-1:0]  f_idx,
  input  logic [IDX_W-1:0]  d_idx,
  input  logic              d_we,
  input  logic [LANES-1:0]  d_be,
  input  logic [DATA_W-1:0] d_wdata,
  output logic [IDX_W-1:0]  ram_idx,
  output logic [LANES-1:0]  ram_be,
  output logic [DATA_W-1:0] ram_wdata,
  output ram_src_e          grant
);
  always_comb begin
    grant     = d_claim ? SRC_DATA : SRC_FETCH;
    ram_idx   = (grant == SRC_DATA) ? d_idx : f_idx;
    ram_be    = (d_claim && d_we) ? d_be : '0;
    ram_wdata = d_wdata;
    if (!f_claim && !d_claim) ram_idx = f_idx;
  end
endmodule

// File: rtl/imem_bram.sv
module imem_bram
  import imem_window_pkg::*;
#(
  parameter int IDX_W  = 10,
  parameter int DATA_W = 32,
  parameter int LANES  = DATA_W / BYTE_W,
  parameter int DEPTH  = 1 << IDX_W
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  idx,
  input  logic [LANES-1:0]  be,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [BYTE_W-1:0] mem [DEPTH];
    logic [BYTE_W-1:0] q_lane;

    always_ff @(posedge clk) begin
      if (be[g]) mem[idx] <= wdata[g*BYTE_W +: BYTE_W];
      q_lane <= mem[idx];
    end

    assign rdata[g*BYTE_W +: BYTE_W] = q_lane;
  end
endmodule

// File: rtl/imem_window.sv
module imem_window
  import imem_window_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'h0001_0000,
  parameter int WIN_BYTES = 4096
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   fetch_en,
  input  logic                   if_req,
  input  logic [ADDR_W-1:0]      if_addr,
  output logic                   if_valid,
  output logic                   if_stall,
  output logic [DATA_W-1:0]      if_data,
  output logic                   ext_req,
  output logic [ADDR_W-1:0]      ext_addr,
  input  logic                   dp_req,
  input  logic                   dp_we,
  input  logic [DATA_W/8-1:0]    dp_be,
  input  logic [ADDR_W-1:0]      dp_addr,
  input  logic [DATA_W-1:0]      dp_wdata,
  output logic                   dp_rvalid,
  output logic [DATA_W-1:0]      dp_rdata
);
  localparam int SIZE_LOG2 = $clog2(WIN_BYTES);
  localparam int LANES     = DATA_W / BYTE_W;
  localparam int OFF_W     = $clog2(LANES);
  localparam int IDX_W     = SIZE_LOG2 - OFF_W;

  logic if_win, dp_win, f_claim, d_claim;
  logic [IDX_W-1:0]  ram_idx;
  logic [LANES-1:0]  ram_be;
  logic [DATA_W-1:0] ram_wdata, ram_q;
  ram_src_e          grant;
  logic              unused_dp_low;

  assign unused_dp_low = ^dp_addr[OFF_W-1:0];

  imem_range_match #(.ADDR_W(ADDR_W), .LSB(SIZE_LOG2), .BASE(WIN_BASE)) u_if_match (
    .tag (if_addr[ADDR_W-1:SIZE_LOG2]),
    .hit (if_win)
  );

  imem_range_match #(.ADDR_W(ADDR_W), .LSB(SIZE_LOG2), .BASE(WIN_BASE)) u_dp_match (
    .tag (dp_addr[ADDR_W-1:SIZE_LOG2]),
    .hit (dp_win)
  );

  assign f_claim = if_req & fetch_en & if_win;
  assign d_claim = dp_req & dp_win;

  imem_port_arb #(.IDX_W(IDX_W), .DATA_W(DATA_W), .LANES(LANES)) u_arb (
    .f_claim   (f_claim),
    .d_claim   (d_claim),
    .f_idx     (if_addr[SIZE_LOG2-1:OFF_W]),
    .d_idx     (dp_addr[SIZE_LOG2-1:OFF_W]),
    .d_we      (dp_we),
    .d_be      (dp_be),
    .d_wdata   (dp_wdata),
    .ram_idx   (ram_idx),
    .ram_be    (ram_be),
    .ram_wdata (ram_wdata),
    .grant     (grant)
  );

  imem_bram #(.IDX_W(IDX_W), .DATA_W(DATA_W), .LANES(LANES)) u_ram (
    .clk   (clk),
    .idx   (ram_idx),
    .be    (ram_be),
    .wdata (ram_wdata),
    .rdata (ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      if_valid  <= 1'b0;
      if_stall  <= 1'b0;
      ext_req   <= 1'b0;
      ext_addr  <= '0;
      dp_rvalid <= 1'b0;
    end else begin
      if_valid  <= f_claim && (grant == SRC_FETCH);
      if_stall  <= f_claim && (grant == SRC_DATA);
      ext_req   <= if_req && !f_claim;
      ext_addr  <= if_addr;
      dp_rvalid <= d_claim && !dp_we;
    end
  end

  assign if_data  = ram_q;
  assign dp_rdata = ram_q;
endmodule

// File: rtl/imem_window_chk.sv
module imem_window_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              fetch_en,
  input logic              if_req,
  input logic [ADDR_W-1:0] if_addr,
  input logic              dp_req,
  input logic              dp_we,
  input logic              if_valid,
  input logic              if_stall,
  input logic              ext_req,
  input logic [ADDR_W-1:0] ext_addr,
  input logic              dp_rvalid
);
  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!if_valid && !if_stall && !ext_req && !dp_rvalid));

  a_r2_hit_needs_enabled_fetch: assert property (@(posedge clk) disable iff (rst)
    if_valid |-> ($past(if_req) && $past(fetch_en) && !ext_req && !if_stall));

  a_r3_miss_carries_address: assert property (@(posedge clk) disable iff (rst)
    ext_req |-> ($past(if_req) && ext_addr == $past(if_addr)));

  a_r4_disabled_never_hits: assert property (@(posedge clk) disable iff (rst)
    (if_req && !fetch_en) |=> (!if_valid && !if_stall));

  a_r6_read_needs_request: assert property (@(posedge clk) disable iff (rst)
    dp_rvalid |-> ($past(dp_req) && !$past(dp_we)));

  a_r8_stall_from_data_port: assert property (@(posedge clk) disable iff (rst)
    if_stall |-> ($past(dp_req) && $past(if_req) && !if_valid && !ext_req));
endmodule

bind imem_window imem_window_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/imem_window_bench.sv
module imem_window_bench;
  localparam logic [31:0] BASE  = 32'h0001_0000;
  localparam int          BYTES = 4096;
  localparam int          WORDS = BYTES / 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fetch_en = 1'b0;
  logic        if_req = 1'b0;
  logic [31:0] if_addr = '0;
  logic        if_valid, if_stall, ext_req, dp_rvalid;
  logic [31:0] if_data, ext_addr, dp_rdata;
  logic        dp_req = 1'b0, dp_we = 1'b0;
  logic [3:0]  dp_be = '0;
  logic [31:0] dp_addr = '0, dp_wdata = '0;

  always #2.5 clk = ~clk;

  imem_window #(.WIN_BASE(BASE), .WIN_BYTES(BYTES)) u_imem_window (
    .clk(clk), .rst(rst), .fetch_en(fetch_en),
    .if_req(if_req), .if_addr(if_addr), .if_valid(if_valid), .if_stall(if_stall),
    .if_data(if_data), .ext_req(ext_req), .ext_addr(ext_addr),
    .dp_req(dp_req), .dp_we(dp_we), .dp_be(dp_be), .dp_addr(dp_addr),
    .dp_wdata(dp_wdata), .dp_rvalid(dp_rvalid), .dp_rdata(dp_rdata)
  );

  typedef struct {
    bit          ifv, stall, ext, dpv;
    logic [31:0] idata, ddata, eaddr;
    int          rid;
  } exp_t;

  exp_t        sb[$];
  logic [31:0] model [WORDS];
  int          checks = 0, fails = 0;

  function automatic bit in_win(logic [31:0] a);
    return (a >= BASE) && (a < BASE + BYTES);
  endfunction

  function automatic int widx(logic [31:0] a);
    return int'(a[11:2]);
  endfunction

  function automatic logic [31:0] wa(int i);
    return BASE + 32'(i * 4);
  endfunction

  // Driver: one cycle of stimulus, expected result pushed into the scoreboard.
  task automatic step(bit ir, logic [31:0] ia, bit dr, bit dw, logic [3:0] be,
                      logic [31:0] da, logic [31:0] wd, int rid);
    exp_t e;
    bit   fin, din;
    fin     = ir && fetch_en && in_win(ia);
    din     = dr && in_win(da);
    e.ifv   = fin && !din;
    e.stall = fin && din;
    e.ext   = ir && !fin;
    e.dpv   = din && !dw;
    e.idata = e.ifv ? model[widx(ia)] : 32'h0;
    e.ddata = e.dpv ? model[widx(da)] : 32'h0;
    e.eaddr = ia;
    e.rid   = rid;
    if (din && dw)
      for (int b = 0; b < 4; b++)
        if (be[b]) model[widx(da)][b*8 +: 8] = wd[b*8 +: 8];
    if_req = ir; if_addr = ia;
    dp_req = dr; dp_we = dw; dp_be = be; dp_addr = da; dp_wdata = wd;
    sb.push_back(e);
    @(negedge clk);
    if_req = 1'b0; dp_req = 1'b0; dp_we = 1'b0; dp_be = '0;
  endtask

  task automatic dwrite(int i, logic [3:0] be, logic [31:0] v, int rid);
    step(1'b0, 32'h0, 1'b1, 1'b1, be, wa(i), v, rid);
  endtask

  task automatic dread(logic [31:0] a, int rid);
    step(1'b0, 32'h0, 1'b1, 1'b0, 4'h0, a, 32'h0, rid);
  endtask

  task automatic fetch(logic [31:0] a, int rid);
    step(1'b1, a, 1'b0, 1'b0, 4'h0, 32'h0, 32'h0, rid);
  endtask

  // Monitor: pops one expected item per clock and compares just after the edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        bit   bad;
        e   = sb.pop_front();
        bad = (if_valid !== e.ifv) || (if_stall !== e.stall) ||
              (ext_req !== e.ext) || (dp_rvalid !== e.dpv) ||
              (e.ifv && if_data !== e.idata) || (e.dpv && dp_rdata !== e.ddata) ||
              (e.ext && ext_addr !== e.eaddr);
        checks++;
        if (bad) begin
          fails++;
          $display("FAIL R%0d actual v=%b s=%b x=%b r=%b id=%h dd=%h xa=%h expected v=%b s=%b x=%b r=%b id=%h dd=%h xa=%h",
                   e.rid, if_valid, if_stall, ext_req, dp_rvalid, if_data, dp_rdata, ext_addr,
                   e.ifv, e.stall, e.ext, e.dpv, e.idata, e.ddata, e.eaddr);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    checks++;
    if (if_valid !== 1'b0 || if_stall !== 1'b0 || ext_req !== 1'b0 || dp_rvalid !== 1'b0) begin
      fails++;
      $display("FAIL R1 actual %b%b%b%b expected 0000", if_valid, if_stall, ext_req, dp_rvalid);
    end

    // R9: copy routine loads the window with fetches disabled
    for (int i = 0; i < 8; i++) dwrite(i, 4'hF, 32'hC0DE_0000 + 32'(i * 32'h111), 9);
    dwrite(WORDS - 1, 4'hF, 32'hFEED_F00D, 9);
    // R4: in-window fetch while disabled goes to the external bus
    fetch(wa(1), 4);
    fetch(wa(WORDS - 1), 4);
    // R6: data read back
    dread(wa(3), 6);
    dread(wa(0), 6);
    // R5: partial byte write, lanes 0 and 2 only
    dwrite(2, 4'b0101, 32'hAABB_CCDD, 5);
    dread(wa(2), 5);
    dwrite(4, 4'b1000, 32'h7700_0000, 5);
    dread(wa(4), 5);
    dread(wa(5), 5);
    // R7: out-of-window write aliasing index 2 and out-of-window read
    step(1'b0, 32'h0, 1'b1, 1'b1, 4'hF, BASE + BYTES + 8, 32'h0, 7);
    step(1'b0, 32'h0, 1'b1, 1'b1, 4'hF, BASE - BYTES + 8, 32'h0, 7);
    dread(wa(2), 7);
    dread(BASE + BYTES + 8, 7);

    @(negedge clk);
    fetch_en = 1'b1;
    // R2: enabled fetches hit with the stored word
    for (int i = 0; i < 8; i++) fetch(wa(i), 2);
    // R10: range boundaries
    fetch(wa(WORDS - 1), 10);
    fetch(BASE + BYTES, 10);
    fetch(BASE - 4, 10);
    // R3: far miss
    fetch(32'h8000_0040, 3);
    // R8: data read beats fetch
    step(1'b1, wa(1), 1'b1, 1'b0, 4'h0, wa(5), 32'h0, 8);
    fetch(wa(1), 8);
    // R8: data write beats fetch and lands
    step(1'b1, wa(1), 1'b1, 1'b1, 4'hF, wa(6), 32'h1234_5678, 8);
    fetch(wa(6), 8);
    // R8: out-of-window data access never stalls
    step(1'b1, wa(3), 1'b1, 1'b0, 4'h0, BASE + BYTES, 32'h0, 8);
    // R3 with R6: miss and data read in the same cycle
    step(1'b1, 32'h0000_0100, 1'b1, 1'b0, 4'h0, wa(7), 32'h0, 3);
    // R9: data port still works while fetches are enabled
    dwrite(9, 4'hF, 32'h0BAD_CAFE, 9);
    fetch(wa(9), 9);

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule